// File: doc/BRIEF.md
# Five-Digit Scan and Data Strobe Generator

This block turns an end-of-conversion pulse from a measurement sequencer into a multiplexed display scan. On that pulse it stores the five BCD result digits and the overrange flag. It then enables one digit select at a time, starting with the most significant digit and moving down. The BCD bus carries the stored digit that belongs to the active select, so one set of segment drivers or an external latch can serve all five positions.

The first scan after each conversion is the strobed scan. An active-low data strobe pulses once in the middle of each digit slot, giving five pulses per conversion. A latch, processor or serial transmitter can take each digit on that strobe. After the strobed scan, a normal result keeps the scan running with no strobes so that the display stays refreshed. An overrange result stops all scanning after the first pass.

The strobe is half a clock period wide. It is formed by gating the low phase of the clock with a registered timing window, which removes the need for a faster clock.

Top module: `digit_scan_strobe`

## Requirements
- R1: While reset is high and after reset is released, with no end-of-conversion seen yet, all digit selects are low, the strobe is high and the BCD bus is zero.
- R2: At most one digit select is high at a time. Selects run from bit 4 (most significant digit) down to bit 0 (least significant digit) and move only to the next lower bit, wrap to bit 4, or go all low.
- R3: In the strobed scan, the most significant select is high for 201 clock cycles, starting in the cycle after the edge that samples end-of-conversion. Each of the other four selects is high for 200 cycles.
- R4: The strobe goes low only in the low half of the clock cycle at slot offset 100. Offset 0 is the first cycle of a slot, so in the first slot this is the 101st cycle. The strobe is always high while the clock is high.
- R5: A conversion produces exactly five strobe pulses, one in each slot of the strobed scan. No further strobes occur until the next end-of-conversion.
- R6: After a strobed scan with no overrange, the scan repeats without a break. Each slot lasts 200 cycles, in the same order, with the strobe held high.
- R7: If overrange was high with end-of-conversion, all selects go low when the strobed scan ends and stay low until the next end-of-conversion.
- R8: While the select for digit i is high, the BCD bus carries stored digit i and is stable for the whole slot. Digit i occupies input bits [4i+3:4i], so bits [19:16] hold the most significant digit. The bus is zero when no select is high.
- R9: Digits and overrange are sampled only at end-of-conversion. Changes on those inputs at any other time have no effect on the bus or on the scan.
- R10: An end-of-conversion at any time, including during a refresh scan, restarts the strobed scan at the most significant digit with a 201-cycle first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; its low phase also shapes the strobe |
| rst | input | 1 | Synchronous active-high reset |
| eoc_pulse | input | 1 | One-cycle end-of-conversion from the sequencer |
| overrange_in | input | 1 | Overrange flag of the finished conversion |
| digits_in | input | 20 | Five BCD digits, digit i in bits [4i+3:4i] |
| digit_sel | output | 5 | One-hot digit selects, bit 4 most significant |
| strobe_n | output | 1 | Active-low half-cycle data strobe |
| bcd_out | output | 4 | BCD digit for the active select |

## Verification
Every result is timed from the rising edge that samples end-of-conversion. The most significant select and its digit appear on the bus one register stage later, and later slots start at 201 + 200·(n−1) cycles after that edge. Each strobe is due in the clock-low half of cycle 100 of its slot. The bench counts cycles from that edge and works out the expected select, bus value and strobe level for every cycle. It samples them two nanoseconds after each falling edge, and it samples the strobe again two nanoseconds after each rising edge to confirm the pulse is only half a cycle wide.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        SCAN_IDLE    = 2'd0,
        SCAN_STROBED = 2'd1,
        SCAN_REFRESH = 2'd2
    } scan_mode_e;

    typedef struct packed {
        scan_mode_e mode;
        logic       active;
    } scan_state_t;

    function automatic logic is_active(input scan_mode_e m);
        return m != SCAN_IDLE;
    endfunction

endpackage

// File: rtl/dss_capture.sv
module dss_capture #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4,
    localparam int BUS_W     = NUM_DIGITS * DIGIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eoc_pulse,
    input  logic             overrange_in,
    input  logic [BUS_W-1:0] digits_in,
    output logic [BUS_W-1:0] digits_q,
    output logic             overrange_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            digits_q    <= '0;
            overrange_q <= 1'b0;
        end else if (eoc_pulse) begin
            digits_q    <= digits_in;
            overrange_q <= overrange_in;
        end
    end
endmodule

// File: rtl/dss_slot_timer.sv
module dss_slot_timer
    import scan_pkg::*;
#(
    parameter int NUM_DIGITS  = 5,
    parameter int SLOT_COUNTS = 200,
    parameter int FIRST_EXTRA = 1,
    localparam int CNT_W      = $clog2(SLOT_COUNTS + FIRST_EXTRA + 1),
    localparam int IDX_W      = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eoc_pulse,
    input  logic             overrange_q,
    output scan_state_t      state,
    output logic [IDX_W-1:0] slot_idx,
    output logic [CNT_W-1:0] slot_cnt
);
    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(NUM_DIGITS - 1);
    localparam logic [CNT_W-1:0] LEN_FIRST = CNT_W'(SLOT_COUNTS + FIRST_EXTRA);
    localparam logic [CNT_W-1:0] LEN_NORM  = CNT_W'(SLOT_COUNTS);

    scan_mode_e       mode_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] slot_len;
    logic             slot_end;

    always_comb begin
        slot_len = (mode_q == SCAN_STROBED && idx_q == TOP_IDX) ? LEN_FIRST : LEN_NORM;
        slot_end = (cnt_q == slot_len - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SCAN_IDLE;
            idx_q  <= '0;
            cnt_q  <= '0;
        end else if (eoc_pulse) begin
            mode_q <= SCAN_STROBED;
            idx_q  <= TOP_IDX;
            cnt_q  <= '0;
        end else if (mode_q != SCAN_IDLE) begin
            if (slot_end) begin
                cnt_q <= '0;
                if (idx_q == '0) begin
                    idx_q <= TOP_IDX;
                    if (mode_q == SCAN_STROBED)
                        mode_q <= overrange_q ? SCAN_IDLE : SCAN_REFRESH;
                end else begin
                    idx_q <= idx_q - IDX_W'(1);
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        state.mode   = mode_q;
        state.active = is_active(mode_q);
        slot_idx     = idx_q;
        slot_cnt     = cnt_q;
    end
endmodule

// File: rtl/dss_strobe_gen.sv
module dss_strobe_gen
    import scan_pkg::*;
#(
    parameter int STROBE_OFFSET = 100,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  scan_state_t      state,
    input  logic [CNT_W-1:0] slot_cnt,
    output logic             strobe_win,
    output logic             strobe_n
);
    always_comb begin
        strobe_win = (state.mode == SCAN_STROBED) && (slot_cnt == CNT_W'(STROBE_OFFSET));
        strobe_n   = ~(strobe_win & ~clk);
    end
endmodule

// File: rtl/digit_scan_strobe.sv
module digit_scan_strobe
    import scan_pkg::*;
#(
    parameter int NUM_DIGITS    = 5,
    parameter int DIGIT_W       = 4,
    parameter int SLOT_COUNTS   = 200,
    parameter int FIRST_EXTRA   = 1,
    parameter int STROBE_OFFSET = 100
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          eoc_pulse,
    input  logic                          overrange_in,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_in,
    output logic [NUM_DIGITS-1:0]         digit_sel,
    output logic                          strobe_n,
    output logic [DIGIT_W-1:0]            bcd_out
);
    localparam int BUS_W = NUM_DIGITS * DIGIT_W;
    localparam int CNT_W = $clog2(SLOT_COUNTS + FIRST_EXTRA + 1);
    localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

    logic [BUS_W-1:0] digits_q;
    logic             overrange_q;
    scan_state_t      state;
    logic [IDX_W-1:0] slot_idx;
    logic [CNT_W-1:0] slot_cnt;
    logic             strobe_win;

    dss_capture #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_capture (
        .clk(clk), .rst(rst), .eoc_pulse(eoc_pulse), .overrange_in(overrange_in),
        .digits_in(digits_in), .digits_q(digits_q), .overrange_q(overrange_q)
    );

    dss_slot_timer #(
        .NUM_DIGITS(NUM_DIGITS), .SLOT_COUNTS(SLOT_COUNTS), .FIRST_EXTRA(FIRST_EXTRA)
    ) u_timer (
        .clk(clk), .rst(rst), .eoc_pulse(eoc_pulse), .overrange_q(overrange_q),
        .state(state), .slot_idx(slot_idx), .slot_cnt(slot_cnt)
    );

    dss_strobe_gen #(.STROBE_OFFSET(STROBE_OFFSET), .CNT_W(CNT_W)) u_strobe (
        .clk(clk), .state(state), .slot_cnt(slot_cnt),
        .strobe_win(strobe_win), .strobe_n(strobe_n)
    );

    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_sel
        assign digit_sel[gi] = state.active && (slot_idx == IDX_W'(gi));
    end

    always_comb begin
        bcd_out = '0;
        if (state.active)
            bcd_out = digits_q[slot_idx*DIGIT_W +: DIGIT_W];
    end
endmodule

// File: rtl/digit_scan_strobe_chk.sv
module digit_scan_strobe_chk #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  eoc_pulse,
    input logic [NUM_DIGITS-1:0] digit_sel,
    input logic [DIGIT_W-1:0]    bcd_out,
    input logic                  strobe_win
);
    localparam logic [NUM_DIGITS-1:0] TOP_SEL = NUM_DIGITS'(1) << (NUM_DIGITS - 1);
    localparam int SC_W = $clog2(NUM_DIGITS + 2);

    logic            past_ok;
    logic [SC_W-1:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
            win_cnt <= '0;
        end else begin
            past_ok <= 1'b1;
            if (eoc_pulse)
                win_cnt <= '0;
            else if (strobe_win && win_cnt <= SC_W'(NUM_DIGITS))
                win_cnt <= win_cnt + SC_W'(1);
        end
    end

    assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(digit_sel));

    assert_shift_order_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(eoc_pulse) && $past(digit_sel) != '0 && digit_sel != $past(digit_sel))
        |-> (digit_sel == ($past(digit_sel) >> 1) || digit_sel == TOP_SEL || digit_sel == '0));

    assert_strobe_in_slot_R4: assert property (@(posedge clk) disable iff (rst)
        strobe_win |-> $countones(digit_sel) == 1);

    assert_strobe_count_R5: assert property (@(posedge clk) disable iff (rst)
        win_cnt <= SC_W'(NUM_DIGITS));

    assert_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
        (digit_sel == '0) |-> (bcd_out == '0));

    assert_bus_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(eoc_pulse) && $stable(digit_sel)) |-> $stable(bcd_out));

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        eoc_pulse |=> (digit_sel == TOP_SEL));
endmodule

bind digit_scan_strobe digit_scan_strobe_chk #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_chk (
    .clk(clk), .rst(rst), .eoc_pulse(eoc_pulse), .digit_sel(digit_sel),
    .bcd_out(bcd_out), .strobe_win(strobe_win)
);

// File: tb/digit_scan_strobe_bench.sv
`timescale 1ns/1ps
module digit_scan_strobe_bench;
    localparam int ND    = 5;
    localparam int SLOT  = 200;
    localparam int FIRST = 201;
    localparam int OFF   = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eoc_pulse = 1'b0;
    logic        overrange_in = 1'b0;
    logic [19:0] digits_in = '0;
    logic [4:0]  digit_sel;
    logic        strobe_n;
    logic [3:0]  bcd_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #10 clk = ~clk;

    digit_scan_strobe u_digit_scan_strobe (
        .clk(clk), .rst(rst), .eoc_pulse(eoc_pulse), .overrange_in(overrange_in),
        .digits_in(digits_in), .digit_sel(digit_sel), .strobe_n(strobe_n), .bcd_out(bcd_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // k counts cycles after the edge that sampled end-of-conversion
    task automatic model(input int k, input bit ovr, output int slot, output int off, output bit strobed);
        int m, r;
        strobed = 0;
        if (k < FIRST) begin
            slot = 0; off = k; strobed = 1;
        end else begin
            m = k - FIRST;
            if (m < (ND - 1) * SLOT) begin
                slot = 1 + m / SLOT; off = m % SLOT; strobed = 1;
            end else if (ovr) begin
                slot = -1; off = 0;
            end else begin
                r = (m - (ND - 1) * SLOT) % (ND * SLOT);
                slot = r / SLOT; off = r % SLOT;
            end
        end
    endtask

    task automatic pulse_eoc(input logic [19:0] dig, input bit ovr);
        @(negedge clk);
        eoc_pulse = 1'b1; overrange_in = ovr; digits_in = dig;
        @(posedge clk); #1;
        eoc_pulse = 1'b0;
    endtask

    task automatic scan_check(input int n, input bit ovr, input logic [19:0] dig,
                              input string ctx, input int exp_strobes);
        int nstb = 0;
        int slot, off;
        bit strobed;
        logic [4:0] exp_sel;
        logic [3:0] exp_bcd;
        bit exp_low;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #2;
            model(k, ovr, slot, off, strobed);
            exp_sel = (slot < 0) ? 5'd0 : (5'd1 << (4 - slot));
            exp_bcd = (slot < 0) ? 4'd0 : dig[(4 - slot) * 4 +: 4];
            exp_low = (slot >= 0) && strobed && (off == OFF);
            chk(digit_sel == exp_sel, ctx, int'(digit_sel), int'(exp_sel));
            chk(bcd_out == exp_bcd, "R8 R9", int'(bcd_out), int'(exp_bcd));
            chk(strobe_n == !exp_low, "R4", int'(strobe_n), int'(!exp_low));
            if (!strobe_n) nstb++;
            @(posedge clk); #2;
            chk(strobe_n == 1'b1, "R4 high phase", int'(strobe_n), 1);
        end
        chk(nstb == exp_strobes, "R5", nstb, exp_strobes);
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and after reset
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        chk(digit_sel == 0, "R1", int'(digit_sel), 0);
        chk(strobe_n == 1, "R1", int'(strobe_n), 1);
        chk(bcd_out == 0, "R1", int'(bcd_out), 0);
        @(negedge clk); rst = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk); #2;
        chk(digit_sel == 0, "R1", int'(digit_sel), 0);
        chk(strobe_n == 1, "R1", int'(strobe_n), 1);
        chk(bcd_out == 0, "R1", int'(bcd_out), 0);

        // R2 R3 R6: normal conversion, strobed scan then two refresh scans; R9 input changes
        pulse_eoc(20'h98765, 1'b0);
        digits_in = 20'h12340;
        overrange_in = 1'b1;
        scan_check(3001, 1'b0, 20'h98765, "R2 R3 R6", 5);

        // R7: overrange conversion stops after the first scan
        pulse_eoc(20'h10293, 1'b1);
        digits_in = 20'h55555;
        overrange_in = 1'b0;
        scan_check(1500, 1'b1, 20'h10293, "R7", 5);

        // R10: restart during a refresh scan
        pulse_eoc(20'h47021, 1'b0);
        scan_check(1537, 1'b0, 20'h47021, "R6", 5);
        pulse_eoc(20'h83659, 1'b0);
        scan_check(1300, 1'b0, 20'h83659, "R10", 5);

        // R10: restart in the middle of a strobed scan
        pulse_eoc(20'h00909, 1'b0);
        scan_check(350, 1'b0, 20'h00909, "R10", 2);
        pulse_eoc(20'h76543, 1'b1);
        scan_check(1100, 1'b1, 20'h76543, "R10 R7", 5);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule